// File: doc/BRIEF.md
# Variable-Block Carry Select Adder

This block adds two unsigned or two's-complement operands and a carry-in, all in one combinational step. It returns the sum, the carry-out and a signed overflow flag. The operand width is divided into consecutive blocks. The least significant block is a carry-lookahead adder fed by the external carry-in. Every block above it holds two lookahead adders: one assumes an incoming carry of 0 and the other assumes 1. The true carry arriving from the block below then picks one result with a multiplexer.

The blocks get wider toward the MSB. The higher blocks wait longer for their selecting carry, so they have time to resolve more bits. The default partition is 4, 4, 5, 6, 7 and 6 bits, which gives a 32-bit adder. The partition is a parameter, and the operand width follows from it. The block is intended for the arithmetic path of a larger datapath, where a short carry path matters more than area.

Top module: `carrySelectAdder`

## Requirements
- R1: `sum` equals (opA + opB + carryIn) modulo 2^WIDTH for every operand pair and carry-in.
- R2: `carryOut` equals bit WIDTH of the full-precision result opA + opB + carryIn.
- R3: `overflow` is 1 exactly when opA and opB have equal sign bits (bit WIDTH-1) and `sum` has the other sign bit. This is the same as the carry into the sign bit differing from the carry out of it.
- R4: WIDTH is the total of the block sizes given by the partition parameter. Each size occupies 8 bits, and block 0 is in the low byte. The default partition 4,4,5,6,7,6 gives a 32-bit adder whose upper blocks start at bits 4, 8, 13, 19 and 26.
- R5: A carry created at any bit position reaches every higher position through all block boundaries. With opA = 2^n - 1, opB = 0 and carryIn = 1, the sum is 2^n and carryOut is 0, for every n below WIDTH. With opA all ones and carryIn = 1, the sum is 0 and carryOut is 1.
- R6: Adding 1 to the largest positive value gives the most negative value with overflow = 1 and carryOut = 0. Adding the most negative value to itself gives sum 0 with overflow = 1 and carryOut = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH (32) | First addend |
| opB | input | WIDTH (32) | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH (32) | Sum modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Signed overflow flag |

## Verification
The bench builds two copies of the adder.

The first copy uses a three-block partition of 2, 3 and 3 bits. This makes an 8-bit adder, so the bench can sweep every operand pair with both carry-in values. That sweep covers every select pattern at both block boundaries, and every sign combination for the overflow flag.

The second copy uses the default 32-bit partition. The bench drives it with a carry injected at every bit position, with the signed-range corner values, and with a run of pseudo-random vectors. Expected values come from wide integer addition.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MAX_BLOCKS = 32;
  localparam int SIZE_BITS  = 8;

  typedef logic [MAX_BLOCKS*SIZE_BITS-1:0] sizeVec_t;

  // Total width of the blocks with index below upto.
  function automatic int sizeBelow(sizeVec_t sizes, int upto);
    int total;
    total = 0;
    for (int k = 0; k < MAX_BLOCKS; k++) begin
      if (k < upto) total += int'(sizes[k*SIZE_BITS +: SIZE_BITS]);
    end
    return total;
  endfunction

  function automatic int sizeOf(sizeVec_t sizes, int idx);
    return int'(sizes[idx*SIZE_BITS +: SIZE_BITS]);
  endfunction
endpackage

// File: rtl/claBlock.sv
module claBlock #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output logic         cOut
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen  = a & b;
  assign prop = a | b;

  // Expanded lookahead: each carry is an OR of generate terms
  // gated by the propagates above them, plus the incoming carry
  // gated by every propagate below.
  always_comb begin
    carry[0] = cIn;
    for (int i = 0; i < W; i++) begin
      logic acc;
      logic allProp;
      acc     = 1'b0;
      allProp = 1'b1;
      for (int j = 0; j <= i; j++) begin
        logic term;
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prop[k];
        acc     = acc | term;
        allProp = allProp & prop[j];
      end
      carry[i+1] = acc | (allProp & cIn);
    end
  end

  assign sum  = a ^ b ^ carry[W-1:0];
  assign cOut = carry[W];

  always_comb begin
    p_cla_arith_r1: assert ({cOut, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cIn)));
  end
endmodule

// File: rtl/selBlock.sv
module selBlock #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output logic         cOut
);
  logic [W-1:0] sumZero;
  logic [W-1:0] sumOne;
  logic         carryZero;
  logic         carryOne;

  claBlock #(.W(W)) uZero (
    .a(a), .b(b), .cIn(1'b0), .sum(sumZero), .cOut(carryZero)
  );

  claBlock #(.W(W)) uOne (
    .a(a), .b(b), .cIn(1'b1), .sum(sumOne), .cOut(carryOne)
  );

  assign sum  = cIn ? sumOne : sumZero;
  assign cOut = carryZero | (carryOne & cIn);

  always_comb begin
    // An assumed carry of 1 can never yield a smaller carry-out than 0.
    p_carry_mono_r5: assert (!(carryZero && !carryOne));
    // The two speculative sums differ by exactly one.
    p_spec_step_r1: assert ((W+1)'({carryZero, sumZero}) + (W+1)'(1) == {carryOne, sumOne});
  end
endmodule

// File: rtl/carrySelectAdder.sv
module carrySelectAdder #(
  parameter int NUM_BLK = 6,
  parameter logic [8*NUM_BLK-1:0] BLK_SIZES = {8'd6, 8'd7, 8'd6, 8'd5, 8'd4, 8'd4},
  localparam int WIDTH = csel_pkg::sizeBelow(csel_pkg::sizeVec_t'(BLK_SIZES), NUM_BLK)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             overflow
);
  localparam csel_pkg::sizeVec_t SIZES = csel_pkg::sizeVec_t'(BLK_SIZES);
  localparam int MSB = WIDTH - 1;

  logic [NUM_BLK:0] blkCarry;
  logic             carryIntoMsb;

  assign blkCarry[0] = carryIn;

  for (genvar k = 0; k < NUM_BLK; k++) begin : gBlk
    localparam int LO = csel_pkg::sizeBelow(SIZES, k);
    localparam int BW = csel_pkg::sizeOf(SIZES, k);
    if (k == 0) begin : gBase
      claBlock #(.W(BW)) uCla (
        .a(opA[LO +: BW]), .b(opB[LO +: BW]), .cIn(blkCarry[k]),
        .sum(sum[LO +: BW]), .cOut(blkCarry[k+1])
      );
    end else begin : gSel
      selBlock #(.W(BW)) uSel (
        .a(opA[LO +: BW]), .b(opB[LO +: BW]), .cIn(blkCarry[k]),
        .sum(sum[LO +: BW]), .cOut(blkCarry[k+1])
      );
    end
  end

  assign carryOut     = blkCarry[NUM_BLK];
  assign carryIntoMsb = opA[MSB] ^ opB[MSB] ^ sum[MSB];
  assign overflow     = carryIntoMsb ^ carryOut;

  always_comb begin
    p_ovf_same_sign_r3: assert (!overflow || (opA[MSB] == opB[MSB]));
    p_ovf_sign_flip_r3: assert (!overflow || (sum[MSB] != opA[MSB]));
    p_carry_out_r2: assert (carryOut == (({1'b0, opA} + {1'b0, opB} + (WIDTH+1)'(carryIn)) >> WIDTH));
  end
endmodule

// File: tb/tb_carrySelectAdder.sv
`timescale 1ns/1ps
module tb_carrySelectAdder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  // Default 32-bit build
  logic [31:0] aBig, bBig, sBig;
  logic        cinBig, coutBig, ovfBig;
  carrySelectAdder dut (
    .opA(aBig), .opB(bBig), .carryIn(cinBig),
    .sum(sBig), .carryOut(coutBig), .overflow(ovfBig)
  );

  // Small 8-bit build: blocks 2,3,3
  logic [7:0] aSm, bSm, sSm;
  logic       cinSm, coutSm, ovfSm;
  carrySelectAdder #(.NUM_BLK(3), .BLK_SIZES({8'd3, 8'd3, 8'd2})) dutSmall (
    .opA(aSm), .opB(bSm), .carryIn(cinSm),
    .sum(sSm), .carryOut(coutSm), .overflow(ovfSm)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runBig(logic [31:0] a, logic [31:0] b, logic cin, string tag);
    logic [32:0] full;
    logic        ovf;
    aBig = a; bBig = b; cinBig = cin;
    #1;
    full = {1'b0, a} + {1'b0, b} + 33'(cin);
    ovf  = (a[31] == b[31]) && (full[31] != a[31]);
    check({tag, " R1 sum"},      64'(sBig),    64'(full[31:0]));
    check({tag, " R2 carry"},    64'(coutBig), 64'(full[32]));
    check({tag, " R3 overflow"}, 64'(ovfBig),  64'(ovf));
  endtask

  initial begin
    #900000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    aBig = '0; bBig = '0; cinBig = 1'b0;
    aSm = '0; bSm = '0; cinSm = 1'b0;
    @(negedge clk);

    // R4: widths follow the partition
    check("R4 default width", 64'($bits(sBig)), 64'd32);
    check("R4 small width",   64'($bits(sSm)),  64'd8);

    // Zero operands
    runBig(32'h0, 32'h0, 1'b0, "zero");

    // Exhaustive sweep of the small build (R1, R2, R3)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] full;
          logic       ovf;
          aSm = 8'(a); bSm = 8'(b); cinSm = 1'(c);
          #1;
          full = 9'(a) + 9'(b) + 9'(c);
          ovf  = (aSm[7] == bSm[7]) && (full[7] != aSm[7]);
          check("small R1 sum",      64'(sSm),    64'(full[7:0]));
          check("small R2 carry",    64'(coutSm), 64'(full[8]));
          check("small R3 overflow", 64'(ovfSm),  64'(ovf));
        end
      end
    end

    // R5: carry injected at bit 0 ripples to every position n
    for (int n = 0; n < 32; n++) begin
      logic [31:0] ones;
      ones = (n == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - n));
      aBig = ones; bBig = 32'h0; cinBig = 1'b1;
      #1;
      check("R5 injected carry sum", 64'(sBig), 64'(32'h1 << n));
      check("R5 injected carry out", 64'(coutBig), 64'd0);
    end
    // R5: boundaries 4, 8, 13, 19, 26 crossed by a generated carry
    runBig(32'h0000_000F, 32'h0000_0001, 1'b0, "R5 b4");
    runBig(32'h0000_00FF, 32'h0000_0001, 1'b0, "R5 b8");
    runBig(32'h0000_1FFF, 32'h0000_0001, 1'b0, "R5 b13");
    runBig(32'h0007_FFFF, 32'h0000_0001, 1'b0, "R5 b19");
    runBig(32'h03FF_FFFF, 32'h0000_0001, 1'b0, "R5 b26");
    aBig = 32'hFFFF_FFFF; bBig = 32'h0; cinBig = 1'b1;
    #1;
    check("R5 all ones sum",   64'(sBig),    64'd0);
    check("R5 all ones carry", 64'(coutBig), 64'd1);

    // R6: signed range corners
    aBig = 32'h7FFF_FFFF; bBig = 32'h1; cinBig = 1'b0;
    #1;
    check("R6 maxpos+1 sum",      64'(sBig),    64'(32'h8000_0000));
    check("R6 maxpos+1 overflow", 64'(ovfBig),  64'd1);
    check("R6 maxpos+1 carry",    64'(coutBig), 64'd0);
    aBig = 32'h8000_0000; bBig = 32'h8000_0000; cinBig = 1'b0;
    #1;
    check("R6 minneg*2 sum",      64'(sBig),    64'd0);
    check("R6 minneg*2 overflow", 64'(ovfBig),  64'd1);
    check("R6 minneg*2 carry",    64'(coutBig), 64'd1);
    runBig(32'h7FFF_FFFF, 32'h0, 1'b1, "R6 cin");
    runBig(32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R3 neg");

    // Pseudo-random vectors on the default build
    for (int i = 0; i < 3000; i++) begin
      runBig($urandom, $urandom, 1'($urandom), "rand");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule